// File: doc/BRIEF.md
# Event Readout Word Formatter

This block turns one validated detector event into a sequence of 32-bit readout words and writes them into a readout FIFO. An event carries, for every germanium channel, two energy values (high range and low range), a crossover-timing TAC value and a fast-trigger TAC value, together with pre-pileup, post-pileup and anti-Compton veto flags for that channel. The event also carries one shield energy value, one shield TAC value and the hit pattern of the shield pairs and germanium channels.

On an accepted event strobe the formatter takes a snapshot of all event inputs, of the per-item readout-enable mask and of the group number. It then walks the enabled items in ascending item number and presents one word per item on a valid/ready write port. Each word carries two qualifier bits, the item number, the group number and a 16-bit payload. The meaning of the qualifier bits depends on the kind of item. Strobes that arrive while a readout is still in progress are dropped and counted. Write attempts into a full FIFO raise a sticky error flag.

Top module: `evt_word_fmt`

## Requirements
- R1: Every word has the qualifier in bits 31:30, the item number in bits 29:24, the snapshot group number in bits 23:16 and the payload in bits 15:0.
- R2: Energy and TAC payloads put the 13-bit value in bits 12:0 and drive bits 15:13 to zero.
- R3: The pattern word carries shield pairs 1..8 in payload bits 7:0, germanium channels A..E in bits 12:8 and zeros in bits 15:13.
- R4: For both germanium energy items, the qualifier is {pileup, veto}, where pileup is pre-pileup OR post-pileup: 00 clean, 01 veto only, 10 pileup only, 11 both.
- R5: For the germanium crossover TAC item, the qualifier is {pre-pileup, post-pileup}.
- R6: The germanium fast-trigger TAC item always carries qualifier 00.
- R7: The shield energy, shield TAC and pattern items always carry qualifier 11.
- R8: Item numbering: germanium channel c (A=0) uses item 4c for high-range energy, 4c+1 for low-range energy, 4c+2 for the crossover TAC and 4c+3 for the fast-trigger TAC. Item 4N is the shield energy, 4N+1 the shield TAC and 4N+2 the pattern, where N is the number of germanium channels. Enabled items are emitted in strictly ascending order, a cleared enable bit skips its item, and an all-zero mask emits no word.
- R9: busy is high from the cycle after an accepted strobe until the cycle after the last word of the event is accepted. An event with an all-zero mask never raises busy.
- R10: A strobe that arrives while busy is high starts nothing and adds one to the drop counter. The drop counter saturates at its maximum value.
- R11: While the FIFO is not ready, the valid signal and the data stay unchanged, and no word is lost.
- R12: The FIFO error flag sets after any cycle in which valid is high and ready is low. It then stays set until reset.
- R13: The event inputs, the mask and the group number are captured at the accepted strobe. Later changes to them do not affect the words of that event.
- R14: After reset, busy, valid, the drop counter and the FIFO error flag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_stb | input | 1 | Validated-event strobe |
| ro_enable | input | 4*NUM_GE+3 | Per-item readout enable, bit i enables item i |
| group_id | input | 8 | Group number placed in every word |
| ge_e_hi | input | NUM_GE*DATA_W | High-range energy per channel, channel c at bits c*DATA_W |
| ge_e_lo | input | NUM_GE*DATA_W | Low-range energy per channel |
| ge_t_co | input | NUM_GE*DATA_W | Crossover-timing TAC per channel |
| ge_t_ft | input | NUM_GE*DATA_W | Fast-trigger TAC per channel |
| ge_pre_pu | input | NUM_GE | Pre-pulse pileup per channel |
| ge_post_pu | input | NUM_GE | Post-pulse pileup per channel |
| ge_veto | input | NUM_GE | Anti-Compton veto per channel |
| bgo_e | input | DATA_W | Shield energy |
| bgo_t | input | DATA_W | Shield TAC |
| hit_bgo | input | NUM_BGO | Shield pair hit bits |
| hit_ge | input | NUM_GE | Germanium hit bits |
| wr_valid | output | 1 | FIFO write valid |
| wr_data | output | 32 | FIFO write word |
| wr_ready | input | 1 | FIFO can accept a word |
| busy | output | 1 | Event readout in progress |
| drop_cnt | output | ERR_W | Saturating count of dropped strobes |
| fifo_err | output | 1 | Sticky write-into-full flag |

## Verification
The bench builds the block with five germanium channels and eight shield pairs. This gives 23 items, so every word kind, both pileup polarities on several channels and the pattern at the top item number are all exercised. It narrows the drop counter to three bits, so saturation at 7 is reached after a handful of strobes injected during long, stalled readouts. Random ready gaps make the FIFO stall many times. Inputs are re-randomised mid-event, which shows that the snapshot is what gets emitted.

// File: rtl/evt_fmt_pkg.sv
package evt_fmt_pkg;

   localparam int QUAL_W    = 2;
   localparam int ITEM_W    = 6;
   localparam int GROUP_W   = 8;
   localparam int PAYLOAD_W = 16;
   localparam int WORD_W    = QUAL_W + ITEM_W + GROUP_W + PAYLOAD_W;

   // kind of item currently selected; decides the qualifier meaning
   typedef enum logic [2:0] {
      K_GE_EHI,
      K_GE_ELO,
      K_GE_TCO,
      K_GE_TFT,
      K_BGO_E,
      K_BGO_T,
      K_PATTERN
   } item_kind_e;

   function automatic logic [WORD_W-1:0] pack_word(
      input logic [QUAL_W-1:0]    qual,
      input logic [ITEM_W-1:0]    item,
      input logic [GROUP_W-1:0]   group,
      input logic [PAYLOAD_W-1:0] payload);
      return {qual, item, group, payload};
   endfunction

endpackage

// File: rtl/evt_lowest_pick.sv
// Lowest-set-bit picker over the pending item mask.
module evt_lowest_pick #(
   parameter int N     = 23,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/evt_qual_enc.sv
// Qualifier encoder; meaning of the two bits depends on the item kind.
module evt_qual_enc
   import evt_fmt_pkg::*;
(
   input  item_kind_e        kind,
   input  logic              pre_pu,
   input  logic              post_pu,
   input  logic              veto,
   output logic [QUAL_W-1:0] qual
);
   always_comb begin
      unique case (kind)
         K_GE_EHI, K_GE_ELO: qual = {pre_pu | post_pu, veto};  // R4
         K_GE_TCO:           qual = {pre_pu, post_pu};         // R5
         K_GE_TFT:           qual = 2'b00;                     // R6
         default:            qual = 2'b11;                     // R7
      endcase
   end
endmodule

// File: rtl/evt_item_sel.sv
// Maps an item number onto its payload, kind and status flags.
module evt_item_sel
   import evt_fmt_pkg::*;
#(
   parameter int NUM_GE  = 5,
   parameter int NUM_BGO = 8,
   parameter int DATA_W  = 13,
   parameter int IDX_W   = 5
) (
   input  logic [IDX_W-1:0]         idx,
   input  logic [NUM_GE*DATA_W-1:0] e_hi,
   input  logic [NUM_GE*DATA_W-1:0] e_lo,
   input  logic [NUM_GE*DATA_W-1:0] t_co,
   input  logic [NUM_GE*DATA_W-1:0] t_ft,
   input  logic [NUM_GE-1:0]        pre_pu,
   input  logic [NUM_GE-1:0]        post_pu,
   input  logic [NUM_GE-1:0]        veto,
   input  logic [DATA_W-1:0]        bgo_e,
   input  logic [DATA_W-1:0]        bgo_t,
   input  logic [NUM_BGO-1:0]       hit_bgo,
   input  logic [NUM_GE-1:0]        hit_ge,
   output item_kind_e               kind,
   output logic [PAYLOAD_W-1:0]     payload,
   output logic                     sel_pre,
   output logic                     sel_post,
   output logic                     sel_veto
);
   localparam int GE_ITEMS = 4 * NUM_GE;

   always_comb begin
      int ch;
      int rel;
      kind     = K_PATTERN;
      payload  = '0;
      sel_pre  = 1'b0;
      sel_post = 1'b0;
      sel_veto = 1'b0;
      ch       = int'(idx) / 4;
      rel      = int'(idx) - GE_ITEMS;
      if (int'(idx) < GE_ITEMS) begin
         sel_pre  = pre_pu[ch];
         sel_post = post_pu[ch];
         sel_veto = veto[ch];
         unique case (idx[1:0])
            2'd0: begin kind = K_GE_EHI; payload[DATA_W-1:0] = e_hi[ch*DATA_W +: DATA_W]; end
            2'd1: begin kind = K_GE_ELO; payload[DATA_W-1:0] = e_lo[ch*DATA_W +: DATA_W]; end
            2'd2: begin kind = K_GE_TCO; payload[DATA_W-1:0] = t_co[ch*DATA_W +: DATA_W]; end
            default: begin kind = K_GE_TFT; payload[DATA_W-1:0] = t_ft[ch*DATA_W +: DATA_W]; end
         endcase
      end else if (rel == 0) begin
         kind = K_BGO_E;
         payload[DATA_W-1:0] = bgo_e;
      end else if (rel == 1) begin
         kind = K_BGO_T;
         payload[DATA_W-1:0] = bgo_t;
      end else begin
         kind = K_PATTERN;                      // R3
         payload[NUM_BGO-1:0]       = hit_bgo;
         payload[NUM_BGO +: NUM_GE] = hit_ge;
      end
   end
endmodule

// File: rtl/evt_word_fmt.sv
// Event readout word formatter: snapshot, ordered walk, FIFO write port.
module evt_word_fmt
   import evt_fmt_pkg::*;
#(
   parameter int NUM_GE    = 5,
   parameter int NUM_BGO   = 8,
   parameter int DATA_W    = 13,
   parameter int ERR_W     = 8,
   parameter int NUM_ITEMS = 4 * NUM_GE + 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     evt_stb,
   input  logic [NUM_ITEMS-1:0]     ro_enable,
   input  logic [GROUP_W-1:0]       group_id,
   input  logic [NUM_GE*DATA_W-1:0] ge_e_hi,
   input  logic [NUM_GE*DATA_W-1:0] ge_e_lo,
   input  logic [NUM_GE*DATA_W-1:0] ge_t_co,
   input  logic [NUM_GE*DATA_W-1:0] ge_t_ft,
   input  logic [NUM_GE-1:0]        ge_pre_pu,
   input  logic [NUM_GE-1:0]        ge_post_pu,
   input  logic [NUM_GE-1:0]        ge_veto,
   input  logic [DATA_W-1:0]        bgo_e,
   input  logic [DATA_W-1:0]        bgo_t,
   input  logic [NUM_BGO-1:0]       hit_bgo,
   input  logic [NUM_GE-1:0]        hit_ge,
   output logic                     wr_valid,
   output logic [WORD_W-1:0]        wr_data,
   input  logic                     wr_ready,
   output logic                     busy,
   output logic [ERR_W-1:0]         drop_cnt,
   output logic                     fifo_err
);
   localparam int IDX_W = $clog2(NUM_ITEMS);

   initial begin
      assert (NUM_ITEMS == 4 * NUM_GE + 3) else $fatal(1, "item count must match channel count");
      assert (NUM_ITEMS <= (1 << ITEM_W)) else $fatal(1, "item number field too narrow");
      assert (NUM_BGO + NUM_GE <= PAYLOAD_W) else $fatal(1, "pattern does not fit payload");
      assert (DATA_W <= PAYLOAD_W) else $fatal(1, "value wider than payload");
      assert (ERR_W >= 1) else $fatal(1, "drop counter needs a bit");
   end

   // ---------------- snapshot (R13) ----------------
   logic                     take;
   logic [NUM_ITEMS-1:0]     pend;
   logic [GROUP_W-1:0]       s_group;
   logic [NUM_GE*DATA_W-1:0] s_e_hi, s_e_lo, s_t_co, s_t_ft;
   logic [NUM_GE-1:0]        s_pre, s_post, s_veto, s_hit_ge;
   logic [DATA_W-1:0]        s_bgo_e, s_bgo_t;
   logic [NUM_BGO-1:0]       s_hit_bgo;

   assign take = evt_stb & ~busy;

   for (genvar c = 0; c < NUM_GE; c++) begin : g_ch
      always_ff @(posedge clk) begin
         if (take) begin
            s_e_hi[c*DATA_W +: DATA_W] <= ge_e_hi[c*DATA_W +: DATA_W];
            s_e_lo[c*DATA_W +: DATA_W] <= ge_e_lo[c*DATA_W +: DATA_W];
            s_t_co[c*DATA_W +: DATA_W] <= ge_t_co[c*DATA_W +: DATA_W];
            s_t_ft[c*DATA_W +: DATA_W] <= ge_t_ft[c*DATA_W +: DATA_W];
            s_pre[c]    <= ge_pre_pu[c];
            s_post[c]   <= ge_post_pu[c];
            s_veto[c]   <= ge_veto[c];
            s_hit_ge[c] <= hit_ge[c];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (take) begin
         s_group   <= group_id;
         s_bgo_e   <= bgo_e;
         s_bgo_t   <= bgo_t;
         s_hit_bgo <= hit_bgo;
      end
   end

   // ---------------- item walk (R8) ----------------
   logic             any_pend;
   logic [IDX_W-1:0] cur_idx;

   evt_lowest_pick #(.N(NUM_ITEMS), .IDX_W(IDX_W)) u_pick (
      .req (pend),
      .any (any_pend),
      .idx (cur_idx)
   );

   item_kind_e           cur_kind;
   logic [PAYLOAD_W-1:0] cur_payload;
   logic                 cur_pre, cur_post, cur_veto;
   logic [QUAL_W-1:0]    cur_qual;

   evt_item_sel #(
      .NUM_GE(NUM_GE), .NUM_BGO(NUM_BGO), .DATA_W(DATA_W), .IDX_W(IDX_W)
   ) u_sel (
      .idx      (cur_idx),
      .e_hi     (s_e_hi),
      .e_lo     (s_e_lo),
      .t_co     (s_t_co),
      .t_ft     (s_t_ft),
      .pre_pu   (s_pre),
      .post_pu  (s_post),
      .veto     (s_veto),
      .bgo_e    (s_bgo_e),
      .bgo_t    (s_bgo_t),
      .hit_bgo  (s_hit_bgo),
      .hit_ge   (s_hit_ge),
      .kind     (cur_kind),
      .payload  (cur_payload),
      .sel_pre  (cur_pre),
      .sel_post (cur_post),
      .sel_veto (cur_veto)
   );

   evt_qual_enc u_qual (
      .kind    (cur_kind),
      .pre_pu  (cur_pre),
      .post_pu (cur_post),
      .veto    (cur_veto),
      .qual    (cur_qual)
   );

   assign busy     = any_pend;                                       // R9
   assign wr_valid = any_pend;
   assign wr_data  = pack_word(cur_qual, ITEM_W'(cur_idx), s_group, cur_payload); // R1

   // ---------------- control state ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend     <= '0;
         drop_cnt <= '0;
         fifo_err <= 1'b0;
      end else begin
         if (take) begin
            pend <= ro_enable;
         end else if (wr_valid && wr_ready) begin
            pend[cur_idx] <= 1'b0;                                   // R11: only on accept
         end
         if (evt_stb && busy && (drop_cnt != {ERR_W{1'b1}})) begin
            drop_cnt <= drop_cnt + 1'b1;                             // R10
         end
         if (wr_valid && !wr_ready) begin
            fifo_err <= 1'b1;                                        // R12
         end
      end
   end

endmodule

// File: rtl/evt_word_fmt_chk.sv
module evt_word_fmt_chk #(
   parameter int NUM_GE = 5,
   parameter int ERR_W  = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             evt_stb,
   input logic             busy,
   input logic             wr_valid,
   input logic [31:0]      wr_data,
   input logic             wr_ready,
   input logic [ERR_W-1:0] drop_cnt,
   input logic             fifo_err
);
   localparam logic [5:0] GE_ITEMS = 6'(4 * NUM_GE);
   localparam logic [5:0] PAT_ITEM = 6'(4 * NUM_GE + 2);

   a_r11_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));

   a_r12_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> fifo_err);

   a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_err |=> fifo_err);

   a_r10_drop_counts: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_stb && busy && (drop_cnt != {ERR_W{1'b1}})) |=> (drop_cnt == $past(drop_cnt) + 1'b1));

   a_r10_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt_stb && busy) |=> $stable(drop_cnt));

   a_r8_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready) |=> (!wr_valid || (wr_data[29:24] > $past(wr_data[29:24]))));

   a_r7_shield_qual: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && (wr_data[29:24] >= GE_ITEMS)) |-> (wr_data[31:30] == 2'b11));

   a_r6_ft_qual: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && (wr_data[29:24] < GE_ITEMS) && (wr_data[25:24] == 2'd3)) |-> (wr_data[31:30] == 2'b00));

   a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && (wr_data[29:24] != PAT_ITEM)) |-> (wr_data[15:13] == 3'b000));

endmodule

bind evt_word_fmt evt_word_fmt_chk #(.NUM_GE(NUM_GE), .ERR_W(ERR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .evt_stb  (evt_stb),
   .busy     (busy),
   .wr_valid (wr_valid),
   .wr_data  (wr_data),
   .wr_ready (wr_ready),
   .drop_cnt (drop_cnt),
   .fifo_err (fifo_err)
);

// File: tb/evt_word_fmt_tb.sv
module evt_word_fmt_tb;
   localparam int NG = 5;
   localparam int NB = 8;
   localparam int DW = 13;
   localparam int EW = 3;
   localparam int NI = 4 * NG + 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic evt_stb = 1'b0;
   logic [NI-1:0] ro_enable = '0;
   logic [7:0] group_id = '0;
   logic [NG*DW-1:0] ge_e_hi = '0, ge_e_lo = '0, ge_t_co = '0, ge_t_ft = '0;
   logic [NG-1:0] ge_pre_pu = '0, ge_post_pu = '0, ge_veto = '0, hit_ge = '0;
   logic [DW-1:0] bgo_e = '0, bgo_t = '0;
   logic [NB-1:0] hit_bgo = '0;
   logic wr_ready = 1'b0;
   logic wr_valid, busy, fifo_err;
   logic [31:0] wr_data;
   logic [EW-1:0] drop_cnt;

   evt_word_fmt #(.NUM_GE(NG), .NUM_BGO(NB), .DATA_W(DW), .ERR_W(EW)) u_dut (
      .clk(clk), .rst_n(rst_n), .evt_stb(evt_stb), .ro_enable(ro_enable),
      .group_id(group_id), .ge_e_hi(ge_e_hi), .ge_e_lo(ge_e_lo),
      .ge_t_co(ge_t_co), .ge_t_ft(ge_t_ft), .ge_pre_pu(ge_pre_pu),
      .ge_post_pu(ge_post_pu), .ge_veto(ge_veto), .bgo_e(bgo_e), .bgo_t(bgo_t),
      .hit_bgo(hit_bgo), .hit_ge(hit_ge), .wr_valid(wr_valid), .wr_data(wr_data),
      .wr_ready(wr_ready), .busy(busy), .drop_cnt(drop_cnt), .fifo_err(fifo_err)
   );

   always #4ns clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   int exp_drop = 0;
   logic exp_err = 1'b0;

   // bench copy of the event as captured at the strobe
   logic [NG*DW-1:0] s_e_hi, s_e_lo, s_t_co, s_t_ft;
   logic [NG-1:0] s_pre, s_post, s_veto, s_hge;
   logic [DW-1:0] s_be, s_bt;
   logic [NB-1:0] s_hb;
   logic [7:0] s_grp;
   logic [31:0] exp_q [0:63];
   int n_exp;

   task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_word(input int item);
      logic [1:0] q;
      logic [15:0] p;
      int c;
      q = 2'b11;
      p = '0;
      c = item / 4;
      if (item < 4 * NG) begin
         case (item % 4)
            0: begin p[DW-1:0] = s_e_hi[c*DW +: DW]; q = {s_pre[c] | s_post[c], s_veto[c]}; end
            1: begin p[DW-1:0] = s_e_lo[c*DW +: DW]; q = {s_pre[c] | s_post[c], s_veto[c]}; end
            2: begin p[DW-1:0] = s_t_co[c*DW +: DW]; q = {s_pre[c], s_post[c]}; end
            default: begin p[DW-1:0] = s_t_ft[c*DW +: DW]; q = 2'b00; end
         endcase
      end else if (item == 4 * NG) begin
         p[DW-1:0] = s_be;
      end else if (item == 4 * NG + 1) begin
         p[DW-1:0] = s_bt;
      end else begin
         p[7:0] = s_hb;
         p[12:8] = s_hge;
      end
      return {q, 6'(item), s_grp, p};
   endfunction

   function automatic string tag_of(input int item);
      if (item >= 4 * NG + 2) return "R1 R8 R3 R7";
      if (item >= 4 * NG) return "R1 R8 R7";
      case (item % 4)
         0, 1: return "R1 R8 R4";
         2: return "R1 R8 R5";
         default: return "R1 R8 R6";
      endcase
   endfunction

   task automatic rand_inputs();
      for (int c = 0; c < NG; c++) begin
         ge_e_hi[c*DW +: DW] = DW'($urandom);
         ge_e_lo[c*DW +: DW] = DW'($urandom);
         ge_t_co[c*DW +: DW] = DW'($urandom);
         ge_t_ft[c*DW +: DW] = DW'($urandom);
      end
      ge_pre_pu = NG'($urandom);
      ge_post_pu = NG'($urandom);
      ge_veto = NG'($urandom);
      hit_ge = NG'($urandom);
      bgo_e = DW'($urandom);
      bgo_t = DW'($urandom);
      hit_bgo = NB'($urandom);
      group_id = 8'($urandom);
   endtask

   // called at a negedge; returns at a negedge
   task automatic run_event(input logic [NI-1:0] mask, input int p_ready, input bit inject);
      int idx;
      int cyc;
      bit stop;
      bit prev_stall;
      logic [31:0] prev_data;
      logic r;
      rand_inputs();
      ro_enable = mask;
      s_e_hi = ge_e_hi; s_e_lo = ge_e_lo; s_t_co = ge_t_co; s_t_ft = ge_t_ft;
      s_pre = ge_pre_pu; s_post = ge_post_pu; s_veto = ge_veto; s_hge = hit_ge;
      s_be = bgo_e; s_bt = bgo_t; s_hb = hit_bgo; s_grp = group_id;
      n_exp = 0;
      for (int i = 0; i < NI; i++) begin
         if (mask[i]) begin
            exp_q[n_exp] = exp_word(i);
            n_exp++;
         end
      end
      evt_stb = 1'b1;
      wr_ready = 1'b0;
      @(negedge clk);
      evt_stb = 1'b0;
      chk(busy == (n_exp != 0), "R9 busy after strobe", 32'(busy), 32'(n_exp != 0));
      idx = 0;
      cyc = 0;
      stop = 1'b0;
      prev_stall = 1'b0;
      prev_data = '0;
      while (idx < n_exp && !stop) begin
         if (inject && cyc == 2) begin
            evt_stb = 1'b1;
            rand_inputs();                   // R13: new values must not leak in
            ro_enable = ~mask;
            if (exp_drop < (1 << EW) - 1) exp_drop++;
         end else begin
            evt_stb = 1'b0;
         end
         r = (($urandom % 100) < 32'(p_ready));
         wr_ready = r;
         if (prev_stall)
            chk(wr_valid && wr_data == prev_data, "R11 held word", wr_data, prev_data);
         if (!wr_valid) begin
            chk(1'b0, "R8 missing word", 32'(idx), 32'(n_exp));
            stop = 1'b1;
         end else if (r) begin
            chk(wr_data == exp_q[idx], inject ? {tag_of(int'(exp_q[idx][29:24])), " R13"}
                                              : tag_of(int'(exp_q[idx][29:24])),
                wr_data, exp_q[idx]);
            if (int'(exp_q[idx][29:24]) != 4 * NG + 2)
               chk(wr_data[15:13] == 3'b000, "R2 upper payload bits", 32'(wr_data[15:13]), 32'd0);
            idx++;
         end else begin
            exp_err = 1'b1;
         end
         prev_stall = wr_valid && !r;
         prev_data = wr_data;
         @(negedge clk);
         cyc++;
         if (cyc > 3000) stop = 1'b1;
      end
      evt_stb = 1'b0;
      wr_ready = 1'b0;
      chk(!busy && !wr_valid, "R9 idle after last word", {30'd0, busy, wr_valid}, 32'd0);
      if (n_exp == 0) begin
         repeat (3) begin
            @(negedge clk);
            chk(!wr_valid && !busy, "R8 empty mask emits nothing", {30'd0, busy, wr_valid}, 32'd0);
         end
      end
      chk(32'(drop_cnt) == 32'(exp_drop), "R10 drop count", 32'(drop_cnt), 32'(exp_drop));
      chk(fifo_err == exp_err, "R12 fifo error flag", 32'(fifo_err), 32'(exp_err));
   endtask

   initial begin
      #1600us;
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog expired actual=hung expected=done");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd7391));
      repeat (3) @(negedge clk);
      chk(!busy && !wr_valid && drop_cnt == '0 && !fifo_err, "R14 reset state",
          {28'd0, busy, wr_valid, |drop_cnt, fifo_err}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed corner cases
      run_event({NI{1'b1}}, 100, 1'b0);                 // full order, no stall
      run_event('0, 100, 1'b0);                          // empty mask
      run_event(NI'(1) << (NI - 1), 100, 1'b0);          // pattern only
      run_event(NI'(1), 100, 1'b0);                      // first item only
      run_event({NI{1'b1}}, 100, 1'b1);                  // strobe while busy
      run_event({NI{1'b1}}, 25, 1'b0);                   // heavy stalls

      // constrained random events
      for (int e = 0; e < 40; e++) begin
         logic [NI-1:0] m;
         m = NI'($urandom);
         if (e % 3 == 0) m = m & NI'($urandom);
         run_event(m, 20 + int'($urandom % 81), (e % 2) == 0);
      end

      // reset clears sticky state
      rst_n = 1'b0;
      @(negedge clk);
      chk(!fifo_err && drop_cnt == '0, "R12 R10 cleared by reset",
          {30'd0, fifo_err, |drop_cnt}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule